// File: doc/BRIEF.md
# Scroll Address Counter

This block holds the 15-bit current video address used by a tile-based background renderer, together with a temporary reload copy of it. The current address is packed, from MSB to LSB, as fine Y (3 bits, bits 14:12), vertical nametable select (bit 11), horizontal nametable select (bit 10), coarse Y (5 bits, bits 9:5) and coarse X (5 bits, bits 4:0). The fetch sequencer reads this packed address directly.

While rendering is enabled on a rendering line, the counter steps through the picture on fixed dots. Coarse X advances after each tile fetch group. Fine Y advances once per line. The horizontal fields are restored from the reload copy at the end of the visible fetch. On the pre-render line the vertical fields are restored over a window of dots. The host loads the reload copy with two alternating scroll writes and a base-select write. The dot and line numbers come from external counters. Each action takes effect on the clock edge that samples the matching dot.

Top module: `scroll_addr_ctr`

## Requirements
- R1: After reset the current address and the reload copy are 0, and the next scroll write is taken as the first of a pair.
- R2: On a rendering line (lines 0 to 239 and the pre-render line 261) with rendering enabled, coarse X increments by one at dots 8, 16, ..., 248 and at prefetch dots 328 and 336.
- R3: At dot 256 of a rendering line, fine Y increments by one and coarse X is left unchanged.
- R4: When coarse X increments from 31, it becomes 0 and bit 10 inverts.
- R5: When fine Y increments from 7, it becomes 0 and coarse Y advances. If coarse Y was 29, it becomes 0 and bit 11 inverts.
- R6: When fine Y wraps with coarse Y at 31, coarse Y becomes 0 and bit 11 is kept.
- R7: At dot 257 of a rendering line, bits 10 and 4:0 of the current address are loaded from the reload copy. All other bits are kept.
- R8: At dots 280 to 304 of the pre-render line only, bits 14:11 and 9:5 are loaded from the reload copy. The same dots on other lines do nothing.
- R9: With rendering disabled, the current address holds its value.
- R10: The first scroll write of a pair places data[7:3] in the reload coarse X. The second places data[7:3] in the reload coarse Y and data[2:0] in the reload fine Y. A base-select write places sel[1] in bit 11 and sel[0] in bit 10. Two zero scroll writes clear all scroll fields.
- R11: Dots and lines not named above leave the current address unchanged. This covers dot 0, dots 258 to 320 outside the pre-render window, dots 337 to 340, and lines 240 to 260.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| render_en_i | input | 1 | Background rendering enabled |
| dot_i | input | 9 | Current dot within the line (0 to 340) |
| line_i | input | 9 | Current line (0 to 261) |
| scroll_wr_i | input | 1 | Scroll write strobe, alternating X then Y |
| scroll_data_i | input | 8 | Scroll write data |
| base_wr_i | input | 1 | Nametable base-select write strobe |
| base_sel_i | input | 2 | Nametable select: [1] vertical, [0] horizontal |
| vaddr_o | output | 15 | Current packed video address |

## Verification
All actions are decoded combinationally from dot_i and line_i and land in one register. The result for a dot is therefore visible on vaddr_o one clock edge after that dot is presented, and the same rule applies to the reload copy after a write. The bench presents each dot on a falling edge and holds it across exactly one rising edge. It then compares on the next falling edge, before the next dot is driven. Long runs of dots are compared only at their end, after every intermediate step has landed.

// File: rtl/scroll_pkg.sv
package scroll_pkg;

  localparam int unsigned CX_W = 5;
  localparam int unsigned CY_W = 5;
  localparam int unsigned FY_W = 3;
  localparam int unsigned VADDR_W = FY_W + 2 + CY_W + CX_W;
  localparam logic [CY_W-1:0] CY_LAST_ROW = CY_W'(29);

  typedef struct packed {
    logic [FY_W-1:0] fine_y;
    logic            nt_v;
    logic            nt_h;
    logic [CY_W-1:0] coarse_y;
    logic [CX_W-1:0] coarse_x;
  } vaddr_t;

  function automatic vaddr_t step_x(vaddr_t a);
    vaddr_t r = a;
    if (&a.coarse_x) begin
      r.coarse_x = '0;
      r.nt_h     = ~a.nt_h;
    end else begin
      r.coarse_x = a.coarse_x + CX_W'(1);
    end
    return r;
  endfunction

  function automatic vaddr_t step_y(vaddr_t a);
    vaddr_t r = a;
    if (!(&a.fine_y)) begin
      r.fine_y = a.fine_y + FY_W'(1);
    end else begin
      r.fine_y = '0;
      if (a.coarse_y == CY_LAST_ROW) begin
        r.coarse_y = '0;
        r.nt_v     = ~a.nt_v;
      end else if (&a.coarse_y) begin
        r.coarse_y = '0;
      end else begin
        r.coarse_y = a.coarse_y + CY_W'(1);
      end
    end
    return r;
  endfunction

endpackage

// File: rtl/scroll_dot_decode.sv
module scroll_dot_decode #(
  parameter int unsigned DOT_W          = 9,
  parameter int unsigned LINE_W         = 9,
  parameter int unsigned VISIBLE_LINES  = 240,
  parameter int unsigned PRERENDER_LINE = 261,
  parameter int unsigned TILE_DOTS      = 8,
  parameter int unsigned FETCH_LAST     = 256,
  parameter int unsigned HCOPY_DOT      = 257,
  parameter int unsigned VCOPY_FIRST    = 280,
  parameter int unsigned VCOPY_LAST     = 304,
  parameter int unsigned PREF_FIRST     = 321,
  parameter int unsigned PREF_LAST      = 336
) (
  input  logic              render_en_i,
  input  logic [DOT_W-1:0]  dot_i,
  input  logic [LINE_W-1:0] line_i,
  output logic              inc_x_o,
  output logic              inc_y_o,
  output logic              copy_h_o,
  output logic              copy_v_o
);
  localparam int unsigned TILE_LSB = $clog2(TILE_DOTS);

  logic render_line, pre_line, tile_end, in_fetch, in_pref, active;

  always_comb begin
    pre_line    = line_i == LINE_W'(PRERENDER_LINE);
    render_line = (line_i < LINE_W'(VISIBLE_LINES)) || pre_line;
    active      = render_en_i && render_line;
    tile_end    = dot_i[TILE_LSB-1:0] == '0;
    // last fetch dot advances fine Y only
    in_fetch    = (dot_i != '0) && (dot_i < DOT_W'(FETCH_LAST));
    in_pref     = (dot_i >= DOT_W'(PREF_FIRST)) && (dot_i <= DOT_W'(PREF_LAST));
    inc_x_o     = active && tile_end && (in_fetch || in_pref);
    inc_y_o     = active && (dot_i == DOT_W'(FETCH_LAST));
    copy_h_o    = active && (dot_i == DOT_W'(HCOPY_DOT));
    copy_v_o    = active && pre_line &&
                  (dot_i >= DOT_W'(VCOPY_FIRST)) && (dot_i <= DOT_W'(VCOPY_LAST));
  end
endmodule

// File: rtl/scroll_tmp_reg.sv
module scroll_tmp_reg
  import scroll_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       scroll_wr_i,
  input  logic [7:0] scroll_data_i,
  input  logic       base_wr_i,
  input  logic [1:0] base_sel_i,
  output vaddr_t     tmp_o
);
  vaddr_t tmp_q;
  logic   second_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tmp_q    <= '0;
      second_q <= 1'b0;
    end else begin
      if (scroll_wr_i) begin
        second_q <= ~second_q;
        if (!second_q) begin
          tmp_q.coarse_x <= scroll_data_i[7:3];
        end else begin
          tmp_q.coarse_y <= scroll_data_i[7:3];
          tmp_q.fine_y   <= scroll_data_i[2:0];
        end
      end
      if (base_wr_i) begin
        tmp_q.nt_v <= base_sel_i[1];
        tmp_q.nt_h <= base_sel_i[0];
      end
    end
  end

  assign tmp_o = tmp_q;
endmodule

// File: rtl/scroll_vaddr_upd.sv
module scroll_vaddr_upd
  import scroll_pkg::*;
(
  input  logic   clk_i,
  input  logic   rst_ni,
  input  logic   inc_x_i,
  input  logic   inc_y_i,
  input  logic   copy_h_i,
  input  logic   copy_v_i,
  input  vaddr_t tmp_i,
  output vaddr_t vaddr_o
);
  vaddr_t v_q, v_d;

  always_comb begin
    v_d = v_q;
    if (inc_x_i) v_d = step_x(v_d);
    if (inc_y_i) v_d = step_y(v_d);
    if (copy_h_i) begin
      v_d.nt_h     = tmp_i.nt_h;
      v_d.coarse_x = tmp_i.coarse_x;
    end
    if (copy_v_i) begin
      v_d.fine_y   = tmp_i.fine_y;
      v_d.nt_v     = tmp_i.nt_v;
      v_d.coarse_y = tmp_i.coarse_y;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) v_q <= '0;
    else         v_q <= v_d;
  end

  assign vaddr_o = v_q;
endmodule

// File: rtl/scroll_addr_ctr.sv
module scroll_addr_ctr
  import scroll_pkg::*;
#(
  parameter int unsigned DOT_W          = 9,
  parameter int unsigned LINE_W         = 9,
  parameter int unsigned VISIBLE_LINES  = 240,
  parameter int unsigned PRERENDER_LINE = 261
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               render_en_i,
  input  logic [DOT_W-1:0]   dot_i,
  input  logic [LINE_W-1:0]  line_i,
  input  logic               scroll_wr_i,
  input  logic [7:0]         scroll_data_i,
  input  logic               base_wr_i,
  input  logic [1:0]         base_sel_i,
  output logic [VADDR_W-1:0] vaddr_o
);
  vaddr_t tmp_q, v_q;
  logic   inc_x, inc_y, copy_h, copy_v;

  scroll_dot_decode #(
    .DOT_W(DOT_W), .LINE_W(LINE_W),
    .VISIBLE_LINES(VISIBLE_LINES), .PRERENDER_LINE(PRERENDER_LINE)
  ) u_dec (
    .render_en_i(render_en_i), .dot_i(dot_i), .line_i(line_i),
    .inc_x_o(inc_x), .inc_y_o(inc_y), .copy_h_o(copy_h), .copy_v_o(copy_v)
  );

  scroll_tmp_reg u_tmp (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .scroll_wr_i(scroll_wr_i), .scroll_data_i(scroll_data_i),
    .base_wr_i(base_wr_i), .base_sel_i(base_sel_i),
    .tmp_o(tmp_q)
  );

  scroll_vaddr_upd u_upd (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .inc_x_i(inc_x), .inc_y_i(inc_y), .copy_h_i(copy_h), .copy_v_i(copy_v),
    .tmp_i(tmp_q), .vaddr_o(v_q)
  );

  assign vaddr_o = v_q;
endmodule

// File: rtl/scroll_addr_ctr_chk.sv
module scroll_addr_ctr_chk #(
  parameter int unsigned DOT_W          = 9,
  parameter int unsigned LINE_W         = 9,
  parameter int unsigned VISIBLE_LINES  = 240,
  parameter int unsigned PRERENDER_LINE = 261
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              render_en_i,
  input logic [DOT_W-1:0]  dot_i,
  input logic [LINE_W-1:0] line_i,
  input logic [14:0]       vaddr_o,
  input logic [14:0]       tmp_q
);
  logic rl, pre;
  assign pre = line_i == LINE_W'(PRERENDER_LINE);
  assign rl  = render_en_i && ((line_i < LINE_W'(VISIBLE_LINES)) || pre);

  assert_hold_when_off_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !render_en_i |=> $stable(vaddr_o));

  assert_idle_lines_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (line_i >= LINE_W'(VISIBLE_LINES)) && !pre |=> $stable(vaddr_o));

  assert_x_step_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rl && (dot_i[2:0] == 3'd0) && (dot_i != '0) && (dot_i < DOT_W'(256)) && ($past(vaddr_o[4:0]) != 5'd31 || 1'b1)
    |=> vaddr_o[4:0] == 5'($past(vaddr_o[4:0]) + 5'd1));

  assert_h_copy_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rl && (dot_i == DOT_W'(257))
    |=> (vaddr_o[4:0] == $past(tmp_q[4:0])) && (vaddr_o[10] == $past(tmp_q[10]))
        && (vaddr_o[14:11] == $past(vaddr_o[14:11])) && (vaddr_o[9:5] == $past(vaddr_o[9:5])));

  assert_v_copy_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rl && pre && (dot_i >= DOT_W'(280)) && (dot_i <= DOT_W'(304))
    |=> (vaddr_o[14:11] == $past(tmp_q[14:11])) && (vaddr_o[9:5] == $past(tmp_q[9:5])));

  assert_y_step_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rl && (dot_i == DOT_W'(256)) && (vaddr_o[14:12] != 3'd7)
    |=> (vaddr_o[14:12] == 3'($past(vaddr_o[14:12]) + 3'd1)) && (vaddr_o[11:0] == $past(vaddr_o[11:0])));
endmodule

bind scroll_addr_ctr scroll_addr_ctr_chk #(
  .DOT_W(DOT_W), .LINE_W(LINE_W),
  .VISIBLE_LINES(VISIBLE_LINES), .PRERENDER_LINE(PRERENDER_LINE)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .render_en_i(render_en_i),
  .dot_i(dot_i), .line_i(line_i), .vaddr_o(vaddr_o), .tmp_q(tmp_q)
);

// File: tb/sim_scroll_addr_ctr.sv
`timescale 1ns/1ps
module sim_scroll_addr_ctr;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        render_en = 1'b0;
  logic [8:0]  dot = '0;
  logic [8:0]  line = '0;
  logic        scroll_wr = 1'b0;
  logic [7:0]  scroll_data = '0;
  logic        base_wr = 1'b0;
  logic [1:0]  base_sel = '0;
  logic [14:0] vaddr;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  scroll_addr_ctr u0 (
    .clk_i(clk), .rst_ni(rst_n), .render_en_i(render_en),
    .dot_i(dot), .line_i(line),
    .scroll_wr_i(scroll_wr), .scroll_data_i(scroll_data),
    .base_wr_i(base_wr), .base_sel_i(base_sel),
    .vaddr_o(vaddr)
  );

  function automatic logic [14:0] mk(int fy, int ntv, int nth, int cy, int cx);
    return {3'(fy), 1'(ntv), 1'(nth), 5'(cy), 5'(cx)};
  endfunction

  task automatic check(string req, logic [14:0] exp);
    n_cmp++;
    if (vaddr !== exp) begin
      n_bad++;
      $display("FAIL %s: vaddr actual 0x%04h expected 0x%04h", req, vaddr, exp);
    end
  endtask

  // drive at falling edge, hold across one rising edge, return at falling edge
  task automatic step(int ln, int dt);
    line = 9'(ln); dot = 9'(dt);
    @(posedge clk); @(negedge clk);
    dot = '0;
  endtask

  task automatic run(int ln, int first, int last);
    for (int d = first; d <= last; d++) step(ln, d);
  endtask

  task automatic wr_scroll(logic [7:0] d);
    line = 9'd250; dot = '0; scroll_wr = 1'b1; scroll_data = d;
    @(posedge clk); @(negedge clk);
    scroll_wr = 1'b0;
  endtask

  task automatic wr_base(logic [1:0] s);
    line = 9'd250; dot = '0; base_wr = 1'b1; base_sel = s;
    @(posedge clk); @(negedge clk);
    base_wr = 1'b0;
  endtask

  // reload the whole address through the pre-render copies
  task automatic load_v(logic [7:0] x, logic [7:0] y, logic [1:0] s);
    wr_scroll(x); wr_scroll(y); wr_base(s);
    step(261, 257); step(261, 280);
  endtask

  task automatic t_reset();
    check("R1 reset", 15'h0000);
  endtask

  task automatic t_visible_line();
    render_en = 1'b1;
    wr_scroll(8'h00); wr_scroll(8'h00);
    run(0, 0, 8);     check("R2 first tile", mk(0,0,0,0,1));
    run(0, 9, 255);   check("R2 31 tiles", mk(0,0,0,0,31));
    step(0, 256);     check("R3 fine Y at 256", mk(1,0,0,0,31));
    step(0, 257);     check("R7 R10 horizontal reload", mk(1,0,0,0,0));
    run(0, 258, 320); check("R11 idle dots", mk(1,0,0,0,0));
    run(0, 321, 336); check("R2 prefetch", mk(1,0,0,0,2));
    run(0, 337, 340); check("R11 tail dots", mk(1,0,0,0,2));
  endtask

  task automatic t_disabled();
    render_en = 1'b0;
    run(1, 0, 340);   check("R9 disabled line", mk(1,0,0,0,2));
    render_en = 1'b1;
  endtask

  task automatic t_vblank();
    run(245, 0, 340); check("R11 vblank line", mk(1,0,0,0,2));
  endtask

  task automatic t_copies();
    wr_scroll(8'h28); wr_scroll(8'h4B); wr_base(2'b11);
    step(261, 257);   check("R7 R10 h copy", mk(1,0,1,0,5));
    step(261, 280);   check("R8 R10 v copy", mk(3,1,1,9,5));
    run(261, 281, 304); check("R8 window", mk(3,1,1,9,5));
    wr_scroll(8'h00); wr_scroll(8'h00); wr_base(2'b00);
    run(3, 280, 304); check("R8 visible no v copy", mk(3,1,1,9,5));
  endtask

  task automatic t_x_wrap();
    load_v(8'hF8, 8'h00, 2'b00); check("R10 load cx31", mk(0,0,0,0,31));
    step(0, 8);       check("R4 coarse X wrap", mk(0,0,1,0,0));
  endtask

  task automatic t_y_wraps();
    load_v(8'h00, 8'hEF, 2'b00); check("R10 load fy7 cy29", mk(7,0,0,29,0));
    step(0, 256);     check("R5 row 29 wrap", mk(0,1,0,0,0));
    load_v(8'h00, 8'hFF, 2'b10); check("R10 load fy7 cy31", mk(7,1,0,31,0));
    step(0, 256);     check("R6 row 31 wrap", mk(0,1,0,0,0));
    load_v(8'h00, 8'h1F, 2'b00); check("R10 load fy7 cy3", mk(7,0,0,3,0));
    step(0, 256);     check("R5 carry into coarse Y", mk(0,0,0,4,0));
  endtask

  initial begin
    @(negedge clk); @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_visible_line();
    t_disabled();
    t_vblank();
    t_copies();
    t_x_wrap();
    t_y_wraps();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        n_cmp++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule